// File: doc/BRIEF.md
# Serial-Programmed Configuration Register Bank

This block lets an external serial master program and inspect a small bank of 8-bit control registers over a four-wire SPI link in mode 0. The serial pins are brought into the local clock domain through synchronisers, and the SPI clock edges are found there. Each access is framed by an active-low chip select and carries exactly three bytes. The first byte is an opcode, the second is a register address and the third is the data. A write opcode stores the data byte. A read opcode returns the addressed register on the serial output while the third byte is being clocked.

Address zero holds a fixed, read-only version byte. The writable registers are presented in parallel on a flat bus for downstream control logic. Dropping chip select at any moment abandons the access. Unknown opcodes and unmapped addresses leave the bank untouched.

Top module: `spi_cfg_regs`

## Requirements
- R1: Serial input is sampled on rising SPI clock edges, serial output changes only on falling SPI clock edges (clock idles low), and every byte travels most-significant bit first.
- R2: In a three-byte frame of opcode, address and data, opcode 0x02 stores the data byte into the addressed register once the eighth bit of the data byte has been sampled.
- R3: Opcode 0x03 drives the addressed register on the serial output during the third byte. The serial output is low during the opcode and address bytes and throughout any write.
- R4: The data byte received during a read has no effect on any register.
- R5: Address 0x00 reads back 0x01, and a write to it changes nothing.
- R6: Registers at addresses 0x01 to 0x04 reset to 0x00. The register at address a appears on cfgRegs bits [8a-1 : 8a-8].
- R7: A write to any address above 0x04 is ignored, and a read of such an address returns 0x00.
- R8: Raising chip select before the frame completes discards the access, including a partial write, and the next frame starts from its first bit.
- R9: The serial output is held low while chip select is high.
- R10: An opcode other than 0x02 or 0x03 makes the rest of the frame change nothing and return a zero output.
- R11: Any 8-bit value, including 0x00, 0x30, 0x8F and 0xFF, is stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, much faster than the SPI clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | SPI serial clock, idle low |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data from the master |
| spiMiso | output | 1 | Serial data to the master, low when not driving read data |
| cfgRegs | output | 32 | Writable registers in parallel, address 1 in the low byte |

## Verification
The main function is exercised with a normal bring-up write sequence, then with power-down values and all-zero and all-ones patterns. These are asymmetric byte patterns, so a bit-order error or an address swap shows up as a wrong readback. Reads of address zero, an address just past the bank and 0xFF separate the version constant from real storage and from the unmapped zero. Writes to those same addresses show whether any of them aliases into the bank. Frames are also cut short at several bit positions, sent with unknown opcodes, and sent as reads carrying 0xFF in the data slot. A cycle-level model of the parallel outputs is compared on every clock, which catches both stray writes and missing writes.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  typedef enum logic [1:0] {
    PH_OPCODE,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } cfg_phase_t;

  typedef struct packed {
    logic active;
    logic shiftEn;
    logic latchAddr;
    logic loadTx;
    logic writeEn;
    logic txShift;
    logic misoClr;
  } cfg_strobe_t;

endpackage

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] OP_WR = 8'h02,
  parameter logic [DATA_W-1:0] OP_RD = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  input  logic [DATA_W-1:0] rxByte,
  output logic              mosiS,
  output cfg_strobe_t       stb
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic sclkPrev;
  logic sclkS, csNS, rise, fall, active, byteDone;
  logic [BIT_W-1:0] bitCnt;
  logic [1:0] byteCnt;
  cfg_phase_t phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      csSync   <= {csSync[SYNC_STAGES-2:0], csNIn};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiIn};
      sclkPrev <= sclkS;
    end
  end

  assign sclkS    = sclkSync[SYNC_STAGES-1];
  assign csNS     = csSync[SYNC_STAGES-1];
  assign mosiS    = mosiSync[SYNC_STAGES-1];
  assign active   = ~csNS;
  assign rise     = active & sclkS & ~sclkPrev;
  assign fall     = active & ~sclkS & sclkPrev;
  assign byteDone = rise & (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      phase   <= PH_OPCODE;
    end else if (!active) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      phase   <= PH_OPCODE;
    end else if (rise) begin
      bitCnt <= byteDone ? '0 : bitCnt + 1'b1;
      if (byteDone && byteCnt != 2'd3) byteCnt <= byteCnt + 1'b1;
      if (byteDone && byteCnt == 2'd0) begin
        if (rxByte == OP_WR)      phase <= PH_WRITE;
        else if (rxByte == OP_RD) phase <= PH_READ;
        else                      phase <= PH_SKIP;
      end
    end
  end

  always_comb begin
    stb           = '0;
    stb.active    = active;
    stb.shiftEn   = rise;
    stb.latchAddr = byteDone & (byteCnt == 2'd1);
    stb.loadTx    = byteDone & (byteCnt == 2'd1) & (phase == PH_READ);
    stb.writeEn   = byteDone & (byteCnt == 2'd2) & (phase == PH_WRITE);
    stb.txShift   = fall & (byteCnt == 2'd2) & (phase == PH_READ);
    stb.misoClr   = ~active | (fall & ~stb.txShift);
  end

endmodule

// File: rtl/spi_cfg_dp.sv
module spi_cfg_dp
  import spi_cfg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter logic [DATA_W-1:0] VERSION = 8'h01
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       mosiS,
  input  cfg_strobe_t                stb,
  output logic [DATA_W-1:0]          rxByte,
  output logic                       miso,
  output logic [NUM_REGS*DATA_W-1:0] cfgRegs
);

  logic [DATA_W-1:0] shiftReg, addrReg, txReg, readData;
  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic misoReg;

  assign rxByte = {shiftReg[DATA_W-2:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrReg  <= '0;
    end else begin
      if (stb.shiftEn)   shiftReg <= rxByte;
      if (stb.latchAddr) addrReg  <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= '0;
    end else if (stb.writeEn) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (addrReg == DATA_W'(i + 1)) regQ[i] <= rxByte;
    end
  end

  always_comb begin
    readData = '0;
    if (rxByte == '0) readData = VERSION;
    for (int i = 0; i < NUM_REGS; i++)
      if (rxByte == DATA_W'(i + 1)) readData = regQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg   <= '0;
      misoReg <= 1'b0;
    end else begin
      if (stb.loadTx) txReg <= readData;
      else if (stb.txShift) txReg <= {txReg[DATA_W-2:0], 1'b0};
      if (stb.txShift)      misoReg <= txReg[DATA_W-1];
      else if (stb.misoClr) misoReg <= 1'b0;
    end
  end

  assign miso = misoReg;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign cfgRegs[g*DATA_W +: DATA_W] = regQ[g];
  end

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] VERSION = 8'h01,
  parameter logic [DATA_W-1:0] OP_WR   = 8'h02,
  parameter logic [DATA_W-1:0] OP_RD   = 8'h03
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       spiSclk,
  input  logic                       spiCsN,
  input  logic                       spiMosi,
  output logic                       spiMiso,
  output logic [NUM_REGS*DATA_W-1:0] cfgRegs
);

  cfg_strobe_t       stb;
  logic              mosiS;
  logic [DATA_W-1:0] rxByte;

  spi_cfg_ctrl #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .OP_WR(OP_WR), .OP_RD(OP_RD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(spiSclk), .csNIn(spiCsN), .mosiIn(spiMosi),
    .rxByte(rxByte), .mosiS(mosiS), .stb(stb)
  );

  spi_cfg_dp #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .VERSION(VERSION)
  ) u_dp (
    .clk(clk), .rstN(rstN), .mosiS(mosiS), .stb(stb),
    .rxByte(rxByte), .miso(spiMiso), .cfgRegs(cfgRegs)
  );

endmodule

// File: rtl/spi_cfg_chk.sv
module spi_cfg_chk
  import spi_cfg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input cfg_strobe_t                stb,
  input logic [DATA_W-1:0]          addrReg,
  input logic                       miso,
  input logic [NUM_REGS*DATA_W-1:0] cfgRegs
);

  assert_miso_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.active |=> !miso);

  assert_no_write_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.active |=> $stable(cfgRegs));

  assert_miso_hold_on_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftEn |=> $stable(miso));

  assert_write_on_rise_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.shiftEn |=> $stable(cfgRegs));

  assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeEn && (addrReg == '0 || addrReg > DATA_W'(NUM_REGS))) |=> $stable(cfgRegs));

endmodule

bind spi_cfg_regs spi_cfg_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .addrReg(u_dp.addrReg),
  .miso(spiMiso), .cfgRegs(cfgRegs)
);

// File: tb/sim_spi_cfg_regs.sv
`timescale 1ns/1ps
module sim_spi_cfg_regs;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso;
  logic [31:0] cfgRegs;

  int errors = 0, checks = 0;
  int holdoff = 0, csHighCnt = 0;
  bit finished = 0;
  logic [7:0] expReg [1:4];

  always #4 clk = ~clk;

  spi_cfg_regs u0 (
    .clk(clk), .rstN(rstN), .spiSclk(sclk), .spiCsN(csN), .spiMosi(mosi),
    .spiMiso(miso), .cfgRegs(cfgRegs)
  );

  task automatic check8(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock reference comparison of the parallel outputs and idle output
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (holdoff > 0) holdoff--;
      else check8("R6/R2 parallel", cfgRegs, {expReg[4], expReg[3], expReg[2], expReg[1]});
      if (csN) csHighCnt++; else csHighCnt = 0;
      if (csHighCnt > 4) check8("R9 idle miso", {31'd0, miso}, 32'd0);
    end
  end

  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input int nbits, output logic [7:0] rx);
    logic [23:0] frame;
    logic sampled;
    frame = {b0, b1, b2};
    rx = 8'h00;
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = frame[23 - i];
      repeat (HALF) @(negedge clk);
      sampled = miso;
      if (i >= 16) rx = {rx[6:0], sampled};
      else check8("R3 low before data byte", {31'd0, sampled}, 32'd0);
      sclk = 1'b1;
      if (i == 23 && b0 == 8'h02 && b1 >= 8'd1 && b1 <= 8'd4) begin
        expReg[b1] = b2;
        holdoff = 6;
      end
      repeat (HALF) @(negedge clk);
      if (i >= 16) check8("R1 miso stable while clock high", {31'd0, miso}, {31'd0, sampled});
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    mosi = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] rx;
    xfer(8'h02, a, d, 24, rx);
    check8("R3 miso low during write", {24'd0, rx}, 32'd0);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] rx;
    xfer(8'h03, a, 8'h00, 24, rx);
    check8(req, {24'd0, rx}, {24'd0, exp});
  endtask

  initial begin
    logic [7:0] rx;
    for (int i = 1; i <= 4; i++) expReg[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    check8("R6 reset value", cfgRegs, 32'd0);
    rdChk("R5 version read", 8'h00, 8'h01);
    rdChk("R6 reset read addr1", 8'h01, 8'h00);

    // bring-up pattern (R2, R1 msb-first via asymmetric values)
    wr(8'h01, 8'h20); wr(8'h02, 8'h20); wr(8'h03, 8'h40); wr(8'h04, 8'h8F);
    check8("R6 field positions", cfgRegs, 32'h8F402020);
    rdChk("R2 read addr1", 8'h01, 8'h20);
    rdChk("R2 read addr3", 8'h03, 8'h40);
    rdChk("R1 msb first addr4", 8'h04, 8'h8F);

    // power-down and extreme values (R11)
    wr(8'h03, 8'h30); wr(8'h04, 8'h00);
    rdChk("R11 addr3 0x30", 8'h03, 8'h30);
    rdChk("R11 addr4 0x00", 8'h04, 8'h00);
    wr(8'h02, 8'hFF);
    rdChk("R11 addr2 0xFF", 8'h02, 8'hFF);

    // read data slot ignored (R4)
    xfer(8'h03, 8'h01, 8'hFF, 24, rx);
    check8("R4 read returns addr1", {24'd0, rx}, 32'h20);
    rdChk("R4 addr1 unchanged", 8'h01, 8'h20);

    // address 0 and unmapped (R5, R7)
    wr(8'h00, 8'h55);
    rdChk("R5 version after write", 8'h00, 8'h01);
    wr(8'h05, 8'hA5);
    wr(8'hFF, 8'h5A);
    rdChk("R7 read addr5", 8'h05, 8'h00);
    rdChk("R7 read addrFF", 8'hFF, 8'h00);
    check8("R7 bank unchanged", cfgRegs, 32'h0030FF20);

    // unknown opcodes (R10)
    xfer(8'h05, 8'h01, 8'hAA, 24, rx);
    check8("R10 zero output", {24'd0, rx}, 32'd0);
    xfer(8'h00, 8'h02, 8'h11, 24, rx);
    check8("R10 zero output op0", {24'd0, rx}, 32'd0);
    check8("R10 bank unchanged", cfgRegs, 32'h0030FF20);

    // aborted frames (R8)
    xfer(8'h02, 8'h01, 8'h77, 23, rx);
    rdChk("R8 partial write discarded", 8'h01, 8'h20);
    xfer(8'h02, 8'h03, 8'h99, 5, rx);
    xfer(8'h03, 8'h02, 8'h00, 19, rx);
    wr(8'h04, 8'hC3);
    rdChk("R8 fresh frame after abort", 8'h04, 8'hC3);
    rdChk("R8 addr3 intact", 8'h03, 8'h30);

    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule